// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block receives asynchronous serial characters on a single line, least significant bit first, and hands each finished character to a holding buffer that a host reads. A programmable divider sets the oversampling rate. The line is sampled sixteen times per bit. Each bit is decided by a two-of-three vote taken around its centre, and any disagreement inside the vote marks the character as noisy. Characters carry 8 data bits, or 9 when the wide mode input is set. In wide mode the top bit goes to a separate output and does not enter the 8-bit buffer.

The host sees five sticky flags: data ready, overrun, framing error, noise and idle line. It also sees one interrupt request gated by two enables and a global mask. A flag is cleared only by a two-step read: a status read, then a data read. If a character completes while the buffer is still full, the buffer keeps its old contents and the new character is dropped. A break (a frame with every bit low) is reported as a framing error, and reception does not resume until the line returns high. A whole character time of high line, after the receiver is enabled or after a character, counts as one idle event.

Control is a six-state machine: `S_OFF`, `S_HUNT`, `S_START`, `S_DATA`, `S_STOP` and `S_REARM`. The transitions are:
- `S_OFF`→`S_HUNT` when enabled.
- `S_HUNT`→`S_START` on a low sample.
- `S_START`→`S_HUNT` when the mid-bit vote reads high (a false start).
- `S_START`→`S_DATA` at the end of the start bit.
- `S_DATA`→`S_STOP` after the last data bit.
- `S_STOP`→`S_HUNT` when the stop vote is high.
- `S_STOP`→`S_REARM` when the stop vote is low.
- `S_REARM`→`S_HUNT` once the line is high.
- Any state→`S_OFF` when the receiver is disabled.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset all five flags, the interrupt, the data output and the ninth-bit output are 0.
- R2: With `nine_i`=0, a frame made of one low start bit, 8 data bits (LSB first) and a high stop bit sets `rdy_o` and places the 8 bits on `rdata_o`, with `r8_o`=0.
- R3: With `nine_i`=1, the frame carries 9 data bits. The low 8 go to `rdata_o` and the ninth (last received) goes to `r8_o`.
- R4: A character that completes while `rdy_o`=1 sets `ovr_o` and leaves `rdata_o` and `r8_o` unchanged. The new character is lost.
- R5: A pulse on `stat_rd_i`, followed later by a pulse on `data_rd_i`, clears all five flags on the clock after the data read. A data read with no earlier status read clears nothing.
- R6: A stop bit voted low sets `frm_o`. A break (all data bits and the stop bit low) gives `frm_o`=1 with data 0, and no further character is taken while the line stays low.
- R7: When the three mid-bit samples of any bit in a frame disagree, `nse_o` is set and the majority value is kept as the bit.
- R8: A low pulse that is high again at the mid-bit vote of the start bit is treated as a false start, and no character is delivered.
- R9: A high line lasting 16×(data bits+2) ticks, after enabling or after a character, sets `idl_o` once. It is set again only after the next character or enable.
- R10: `irq_o` = not `gmask_i` and ((`rie_i` and (`rdy_o` or `ovr_o`)) or (`iie_i` and `idl_o`)).
- R11: While `rx_en_i`=0 the receiver stays in `S_OFF` and no character is received.
- R12: The oversampling tick occurs every `div_i`+1 clocks, and one bit lasts 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Serial receive line, idle high |
| rx_en_i | input | 1 | Receiver enable |
| nine_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| div_i | input | DIV_W | Tick divider, one tick every div_i+1 clocks |
| rie_i | input | 1 | Receive interrupt enable |
| iie_i | input | 1 | Idle interrupt enable |
| gmask_i | input | 1 | Global interrupt mask, 1 blocks the interrupt |
| stat_rd_i | input | 1 | Status read strobe |
| data_rd_i | input | 1 | Data read strobe |
| rdata_o | output | DATA_W | Receive buffer |
| r8_o | output | 1 | Ninth data bit of the buffered character |
| rdy_o | output | 1 | Data ready flag |
| ovr_o | output | 1 | Overrun flag |
| frm_o | output | 1 | Framing error flag |
| nse_o | output | 1 | Noise flag |
| idl_o | output | 1 | Idle line flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The ready, error and data outputs change one clock after the stop-bit vote. With a divider of 0, that vote lands about 16×(data bits+1)+12 clocks after the start edge, which includes two synchronizer stages. The bench therefore waits until the whole stop bit has been sent plus eight clocks before it samples.

The idle flag is due 16×(data bits+2) ticks after arming. It is checked once well before that deadline and once well after it.

The interrupt follows the flags and enables within the same cycle. A clear takes effect on the clock after the data-read strobe, so every check after a clear waits at least one further falling edge. All inputs change on falling edges, and all outputs are read on falling edges.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // oversampling rate and the three vote positions inside one bit
    localparam int OVS   = 16;
    localparam int OVS_W = $clog2(OVS);
    localparam logic [OVS_W-1:0] SMP_A   = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] SMP_B   = OVS_W'(OVS / 2);
    localparam logic [OVS_W-1:0] SMP_C   = OVS_W'(OVS / 2 + 1);
    localparam logic [OVS_W-1:0] SMP_END = OVS_W'(OVS - 1);

    typedef enum logic [2:0] {
        S_OFF,
        S_HUNT,
        S_START,
        S_DATA,
        S_STOP,
        S_REARM
    } rx_state_e;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (!en_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= div_i) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    // R12: with a divider above zero, two ticks are never adjacent
    p_tick_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            nine_i,
    input  logic            tick_i,
    input  logic            rxd_i,
    output logic            done_o,
    output logic [DATA_W:0] data_o,
    output logic            frm_o,
    output logic            nse_o,
    output logic            idle_o
);

    localparam int SH_W   = DATA_W + 1;
    localparam int BIT_W  = $clog2(SH_W + 1);
    localparam int IDLE_W = $clog2(OVS * (SH_W + 2) + 1);
    localparam logic [BIT_W-1:0]  LAST_N = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0]  LAST_W = BIT_W'(DATA_W);
    localparam logic [IDLE_W-1:0] IDLE_N = IDLE_W'(OVS * (DATA_W + 2) - 1);
    localparam logic [IDLE_W-1:0] IDLE_W_LIM = IDLE_W'(OVS * (DATA_W + 3) - 1);

    rx_state_e         state_q, state_d;
    logic              sync_q, rx_s;
    logic [OVS_W-1:0]  scnt_q;
    logic [BIT_W-1:0]  bidx_q;
    logic [SH_W-1:0]   sh_q;
    logic              smp_a_q, smp_b_q, nse_q;
    logic              idle_arm_q;
    logic [IDLE_W-1:0] idle_cnt_q;

    logic              mid, end_bit, vote, split, counting, finish;
    logic [BIT_W-1:0]  last_bit;
    logic [IDLE_W-1:0] idle_lim;

    assign mid      = tick_i && (scnt_q == SMP_C);
    assign end_bit  = tick_i && (scnt_q == SMP_END);
    assign vote     = maj3(smp_a_q, smp_b_q, rx_s);
    assign split    = !((smp_a_q == smp_b_q) && (smp_b_q == rx_s));
    assign last_bit = nine_i ? LAST_W : LAST_N;
    assign idle_lim = nine_i ? IDLE_W_LIM : IDLE_N;
    assign counting = (state_q inside {S_START, S_DATA, S_STOP}) &&
                      (state_d inside {S_START, S_DATA, S_STOP});
    assign finish   = (state_q == S_STOP) && mid && en_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:   state_d = S_HUNT;
                S_HUNT:  if (tick_i && !rx_s) state_d = S_START;
                S_START: begin
                    if (mid && vote)  state_d = S_HUNT;
                    else if (end_bit) state_d = S_DATA;
                end
                S_DATA:  if (end_bit && bidx_q == last_bit) state_d = S_STOP;
                S_STOP:  if (mid) state_d = vote ? S_HUNT : S_REARM;
                S_REARM: if (rx_s) state_d = S_HUNT;
                default: state_d = S_OFF;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= 1'b1;
            rx_s       <= 1'b1;
            scnt_q     <= '0;
            bidx_q     <= '0;
            sh_q       <= '0;
            smp_a_q    <= 1'b1;
            smp_b_q    <= 1'b1;
            nse_q      <= 1'b0;
            idle_arm_q <= 1'b0;
            idle_cnt_q <= '0;
            done_o     <= 1'b0;
            data_o     <= '0;
            frm_o      <= 1'b0;
            nse_o      <= 1'b0;
            idle_o     <= 1'b0;
        end else begin
            sync_q <= rxd_i;
            rx_s   <= sync_q;
            done_o <= 1'b0;
            idle_o <= 1'b0;

            if (counting) begin
                if (tick_i) scnt_q <= scnt_q + 1'b1;
            end else begin
                scnt_q <= '0;
            end

            if (tick_i && scnt_q == SMP_A) smp_a_q <= rx_s;
            if (tick_i && scnt_q == SMP_B) smp_b_q <= rx_s;

            if (state_q == S_HUNT)  nse_q <= 1'b0;
            else if (mid && split)  nse_q <= 1'b1;

            if (state_q == S_START)                bidx_q <= '0;
            else if (state_q == S_DATA && end_bit) bidx_q <= bidx_q + 1'b1;

            if (state_q == S_DATA && mid) sh_q <= {vote, sh_q[SH_W-1:1]};

            if (finish) begin
                done_o <= 1'b1;
                data_o <= nine_i ? sh_q : {1'b0, sh_q[SH_W-1:1]};
                frm_o  <= !vote;
                nse_o  <= nse_q | split;
            end

            // idle line: a full character time of high line, once per arming
            if (state_q != S_HUNT || !rx_s) begin
                idle_cnt_q <= '0;
            end else if (tick_i && idle_arm_q) begin
                if (idle_cnt_q == idle_lim) begin
                    idle_o     <= 1'b1;
                    idle_arm_q <= 1'b0;
                    idle_cnt_q <= '0;
                end else begin
                    idle_cnt_q <= idle_cnt_q + 1'b1;
                end
            end
            if ((state_q == S_OFF && en_i) || finish) idle_arm_q <= 1'b1;
        end
    end

    // R11: disabling parks the machine
    p_off_when_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> state_q == S_OFF);
    // R9: one idle event per arming
    p_idle_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |=> !idle_o);
    // R6: a low stop bit forces a wait for the line to return high
    p_break_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && frm_o) |-> (state_q == S_REARM || state_q == S_OFF));
    // R2: a character is only delivered out of the stop bit
    p_done_from_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state_q) == S_STOP);

endmodule

// File: rtl/uart_rx_regs.sv
module uart_rx_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W:0]   data_i,
    input  logic              frm_i,
    input  logic              nse_i,
    input  logic              idle_i,
    input  logic              stat_rd_i,
    input  logic              data_rd_i,
    input  logic              rie_i,
    input  logic              iie_i,
    input  logic              gmask_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              r8_o,
    output logic              rdy_o,
    output logic              ovr_o,
    output logic              frm_o,
    output logic              nse_o,
    output logic              idl_o,
    output logic              irq_o
);

    logic arm_q, clr, xfer, lost;

    assign clr  = data_rd_i && arm_q;
    assign xfer = done_i && !rdy_o;
    assign lost = done_i && rdy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q   <= 1'b0;
            rdata_o <= '0;
            r8_o    <= 1'b0;
            rdy_o   <= 1'b0;
            ovr_o   <= 1'b0;
            frm_o   <= 1'b0;
            nse_o   <= 1'b0;
            idl_o   <= 1'b0;
        end else begin
            arm_q <= stat_rd_i | (arm_q & !clr);
            if (xfer) begin
                rdata_o <= data_i[DATA_W-1:0];
                r8_o    <= data_i[DATA_W];
            end
            rdy_o <= xfer | (rdy_o & !clr);
            ovr_o <= lost | (ovr_o & !clr);
            frm_o <= (xfer & frm_i) | (frm_o & !clr);
            nse_o <= (xfer & nse_i) | (nse_o & !clr);
            idl_o <= idle_i | (idl_o & !clr);
        end
    end

    assign irq_o = !gmask_i && ((rie_i && (rdy_o || ovr_o)) || (iie_i && idl_o));

    // R2: ready only rises after a delivered character
    p_rdy_from_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> $past(done_i));
    // R4: a character arriving on a full buffer leaves the buffer alone
    p_ovr_keeps_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> ($stable(rdata_o) && $stable(r8_o)));
    // R4: overrun only from a character meeting a full buffer
    p_ovr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $past(done_i && rdy_o));
    // R5: ready only falls after a status read then a data read
    p_clear_needs_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_o) |-> $past(arm_q && data_rd_i));

endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              rx_en_i,
    input  logic              nine_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              rie_i,
    input  logic              iie_i,
    input  logic              gmask_i,
    input  logic              stat_rd_i,
    input  logic              data_rd_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              r8_o,
    output logic              rdy_o,
    output logic              ovr_o,
    output logic              frm_o,
    output logic              nse_o,
    output logic              idl_o,
    output logic              irq_o
);

    logic            tick;
    logic            done;
    logic [DATA_W:0] chr;
    logic            c_frm, c_nse, idle_ev;

    uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (rx_en_i),
        .div_i  (div_i),
        .tick_o (tick)
    );

    uart_rx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (rx_en_i),
        .nine_i (nine_i),
        .tick_i (tick),
        .rxd_i  (rxd_i),
        .done_o (done),
        .data_o (chr),
        .frm_o  (c_frm),
        .nse_o  (c_nse),
        .idle_o (idle_ev)
    );

    uart_rx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done),
        .data_i    (chr),
        .frm_i     (c_frm),
        .nse_i     (c_nse),
        .idle_i    (idle_ev),
        .stat_rd_i (stat_rd_i),
        .data_rd_i (data_rd_i),
        .rie_i     (rie_i),
        .iie_i     (iie_i),
        .gmask_i   (gmask_i),
        .rdata_o   (rdata_o),
        .r8_o      (r8_o),
        .rdy_o     (rdy_o),
        .ovr_o     (ovr_o),
        .frm_o     (frm_o),
        .nse_o     (nse_o),
        .idl_o     (idl_o),
        .irq_o     (irq_o)
    );

endmodule

// File: tb/uart_rx_stat_bench.sv
module uart_rx_stat_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       nine = 1'b0;
    logic [11:0] div = '0;
    logic       rie = 1'b0, iie = 1'b0, gmask = 1'b0;
    logic       stat_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] rdata;
    logic       r8, rdy, ovr, frm, nse, idl, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    uart_rx_stat u_uart_rx_stat (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .rx_en_i(rx_en), .nine_i(nine),
        .div_i(div), .rie_i(rie), .iie_i(iie), .gmask_i(gmask),
        .stat_rd_i(stat_rd), .data_rd_i(data_rd), .rdata_o(rdata), .r8_o(r8),
        .rdy_o(rdy), .ovr_o(ovr), .frm_o(frm), .nse_o(nse), .idl_o(idl), .irq_o(irq)
    );

    // fields: nine | data9 | stop | glitch bit (15 none) | exp data | exp r8 | exp frm | exp nse
    localparam int NV = 6;
    localparam logic [25:0] VEC [NV] = '{
        {1'b0, 9'h0A5, 1'b1, 4'hF, 8'hA5, 1'b0, 1'b0, 1'b0},
        {1'b0, 9'h03C, 1'b1, 4'hF, 8'h3C, 1'b0, 1'b0, 1'b0},
        {1'b1, 9'h15A, 1'b1, 4'hF, 8'h5A, 1'b1, 1'b0, 1'b0},
        {1'b1, 9'h0FF, 1'b1, 4'hF, 8'hFF, 1'b0, 1'b0, 1'b0},
        {1'b0, 9'h081, 1'b0, 4'hF, 8'h81, 1'b0, 1'b1, 1'b0},
        {1'b0, 9'h055, 1'b1, 4'h2, 8'h55, 1'b0, 1'b0, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // starts right after a falling edge; bit b, offset k is driven for one clock
    task automatic send(input logic nb9, input logic [8:0] d, input logic stop,
                        input int gl, input int blen);
        int nb;
        nb = nb9 ? 9 : 8;
        for (int b = 0; b < nb + 2; b++) begin
            logic v;
            if (b == 0)       v = 1'b0;
            else if (b <= nb) v = d[b-1];
            else              v = stop;
            for (int k = 0; k < blen; k++) begin
                rxd = (b == gl && k == 9) ? ~v : v;
                @(negedge clk);
            end
        end
        rxd = 1'b1;
    endtask

    task automatic clear_flags();
        stat_rd = 1'b1; @(negedge clk);
        stat_rd = 1'b0; repeat (2) @(negedge clk);
        data_rd = 1'b1; @(negedge clk);
        data_rd = 1'b0; @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 rdy", rdy, 0); check("R1 ovr", ovr, 0); check("R1 frm", frm, 0);
        check("R1 nse", nse, 0); check("R1 idl", idl, 0); check("R1 irq", irq, 0);
        check("R1 rdata", rdata, 0); check("R1 r8", r8, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R11 receiver disabled
        send(1'b0, 9'h042, 1'b1, 15, 16);
        repeat (20) @(negedge clk);
        check("R11 rdy while disabled", rdy, 0);

        // R9 / R10 idle after enable
        iie = 1'b1;
        rx_en = 1'b1;
        repeat (120) @(negedge clk);
        check("R9 idl early", idl, 0);
        repeat (80) @(negedge clk);
        check("R9 idl due", idl, 1);
        check("R10 idle irq", irq, 1);
        clear_flags();
        check("R5 idl cleared", idl, 0);
        repeat (400) @(negedge clk);
        check("R9 idl once", idl, 0);
        iie = 1'b0;

        // R2 R3 R6 R7 vector table
        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            clear_flags();
            nine = v[25];
            repeat (20) @(negedge clk);
            send(v[25], v[24:16], v[15], int'(v[14:11]), 16);
            repeat (8) @(negedge clk);
            check("R2 rdy", rdy, 1);
            check("R2/R3 rdata", rdata, v[10:3]);
            check("R3 r8", r8, v[2]);
            check("R6 frm", frm, v[1]);
            check("R7 nse", nse, v[0]);
            check("R4 no ovr", ovr, 0);
        end
        nine = 1'b0;

        // R5 data read alone does not clear
        clear_flags();
        repeat (10) @(negedge clk);
        send(1'b0, 9'h077, 1'b1, 15, 16);
        repeat (8) @(negedge clk);
        data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
        check("R5 rdy after lone data read", rdy, 1);
        check("R5 rdata", rdata, 8'h77);
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        repeat (3) @(negedge clk);
        data_rd = 1'b1; @(negedge clk); data_rd = 1'b0; @(negedge clk);
        check("R5 rdy after sequence", rdy, 0);

        // R4 overrun
        repeat (10) @(negedge clk);
        send(1'b0, 9'h011, 1'b1, 15, 16);
        repeat (20) @(negedge clk);
        send(1'b0, 9'h022, 1'b1, 15, 16);
        repeat (8) @(negedge clk);
        check("R4 rdy", rdy, 1);
        check("R4 ovr", ovr, 1);
        check("R4 data kept", rdata, 8'h11);
        rie = 1'b1; @(negedge clk);
        check("R10 rx irq", irq, 1);
        gmask = 1'b1; @(negedge clk);
        check("R10 masked irq", irq, 0);
        gmask = 1'b0; rie = 1'b0;
        clear_flags();
        check("R5 ovr cleared", ovr, 0);
        check("R5 rdy cleared", rdy, 0);

        // R6 break then long low line
        repeat (10) @(negedge clk);
        send(1'b0, 9'h000, 1'b0, 15, 16);
        rxd = 1'b0;
        repeat (40) @(negedge clk);
        check("R6 break rdy", rdy, 1);
        check("R6 break frm", frm, 1);
        check("R6 break data", rdata, 0);
        rxd = 1'b1;
        repeat (60) @(negedge clk);
        check("R6 no frame while low", ovr, 0);

        // R8 false start
        clear_flags();
        rxd = 1'b0; repeat (4) @(negedge clk);
        rxd = 1'b1; repeat (200) @(negedge clk);
        check("R8 no char", rdy, 0);
        check("R8 no frm", frm, 0);

        // R12 slower divider
        div = 12'd2;
        repeat (10) @(negedge clk);
        send(1'b0, 9'h0C3, 1'b1, 15, 48);
        repeat (20) @(negedge clk);
        check("R12 rdy", rdy, 1);
        check("R12 rdata", rdata, 8'hC3);

        finish_run();
    end

endmodule